// File: doc/BRIEF.md
# Post-Divider with Power-Down Stepping

This block turns a fast VCO clock into the output clock by dividing it by 1, 2, 4 or 8, as chosen by a two-bit select. The output keeps a 50% duty cycle at every ratio. A power-down request adds a further divide-by-16 on top of the programmed ratio.

The extra division is not applied all at once. A pacing counter clocked by the slow reference clock moves an extra-divide exponent one step at a time: 1, 2, 4, 8, then 16 on entry, and back through 8, 4, 2, 1 on exit. Each step lasts a fixed number of reference cycles. The exponent is Gray-coded and passed into the VCO domain through two flops. A new total ratio is loaded only when an output period ends, so no short pulse ever appears on the output.

Top module: `post_div_pdstep`

## Requirements
- R1: With no power-down in effect, the output period is 2^`nsel` VCO cycles: code 0 divides by 1, 1 by 2, 2 by 4 and 3 by 8.
- R2: Every output period is high for exactly half its length. At divide-by-1 the output is a copy of the VCO clock.
- R3: While `pwr_dn` stays high, the extra divide factor climbs through 2, 4, 8 and 16 in that order, and then holds at 16.
- R4: Each step of the extra factor lasts `STEP_REF_CYCLES` (16) reference-clock cycles. Only one step is taken at a time, and the Gray-coded step index changes in one bit at a time.
- R5: After `pwr_dn` is released, the extra factor falls back through 8, 4, 2 and 1, one step at a time, and then holds at 1.
- R6: A ratio change takes effect only at the end of a full output period. Every output period is a whole power of two of VCO cycles, with no runt pulse.
- R7: While `rst_n` is low, the output is low. After reset, the step index is 0 and the output runs at the programmed ratio with no extra division.
- R8: If `pwr_dn` falls before the extra factor reaches 16, the factor reverses from the step it has reached and steps back down to 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| vco_clk | input | 1 | Fast clock to be divided |
| ref_clk | input | 1 | Slow reference clock that paces the power-down steps |
| rst_n | input | 1 | Asynchronous active-low reset for both clock domains |
| nsel | input | 2 | Programmed ratio select: divide by 2^nsel |
| pwr_dn | input | 1 | Power-down request, asynchronous to both clocks |
| fout | output | 1 | Divided output clock |

## Verification
A corrupted period counter or active exponent shows up within one output period. It appears as a period that is not a power of two or as a high time that is not half the period. A step index that skips, stalls or runs in the wrong direction shows up as a wrong sequence of distinct output periods, or as a dwell between changes far from 16 reference cycles. It is visible at the first period boundary after the step falls due. A missing boundary guard shows as a runt period at the moment of a ratio change.

// File: rtl/post_div_pdstep.sv
module post_div_pdstep #(
  parameter int STEP_REF_CYCLES = 16,
  parameter int PD_STEPS        = 4
) (
  input  logic       vco_clk,
  input  logic       ref_clk,
  input  logic       rst_n,
  input  logic [1:0] nsel,
  input  logic       pwr_dn,
  output logic       fout
);
  localparam int SW   = $clog2(PD_STEPS + 1);
  localparam int MAXE = 3 + PD_STEPS;
  localparam int EW   = $clog2(MAXE + 1);
  localparam int PW   = $clog2(STEP_REF_CYCLES);

  // reference-clock domain: request sync, pacing, step index
  logic [1:0]    pd_meta;
  logic          pd_s;
  logic [SW-1:0] step, step_gray;
  logic [PW-1:0] pace;
  logic          want_up, want_dn;

  assign pd_s    = pd_meta[1];
  assign want_up = pd_s && (step != SW'(PD_STEPS));
  assign want_dn = !pd_s && (step != '0);

  always_ff @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n) begin
      pd_meta   <= '0;
      step      <= '0;
      step_gray <= '0;
      pace      <= '0;
    end else begin
      pd_meta   <= {pd_meta[0], pwr_dn};
      step_gray <= step ^ (step >> 1);
      if (!(want_up || want_dn)) begin
        pace <= '0;
      end else if (pace == PW'(STEP_REF_CYCLES - 1)) begin
        pace <= '0;
        step <= want_up ? step + 1'b1 : step - 1'b1;
      end else begin
        pace <= pace + 1'b1;
      end
    end
  end

  // VCO-clock domain
  function automatic logic [SW-1:0] gray2bin(input logic [SW-1:0] g);
    logic [SW-1:0] b;
    b[SW-1] = g[SW-1];
    for (int i = SW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  logic [SW-1:0]   g_m, g_s;
  logic [EW-1:0]   e_req, e_act, e_n;
  logic [MAXE-1:0] cnt, cnt_n, top, top_n;
  logic            last, div_q, div_n, bypass;

  assign e_req = EW'(nsel) + EW'(gray2bin(g_s));
  assign top   = ~({MAXE{1'b1}} << e_act);
  assign last  = (cnt == top);

  always_comb begin
    e_n   = last ? e_req : e_act;
    cnt_n = last ? '0 : cnt + 1'b1;
    top_n = ~({MAXE{1'b1}} << e_n);
    div_n = (cnt_n <= (top_n >> 1));
  end

  always_ff @(posedge vco_clk or negedge rst_n) begin
    if (!rst_n) begin
      g_m    <= '0;
      g_s    <= '0;
      e_act  <= '0;
      cnt    <= '0;
      div_q  <= 1'b0;
      bypass <= 1'b0;
    end else begin
      g_m    <= step_gray;
      g_s    <= g_m;
      e_act  <= e_n;
      cnt    <= cnt_n;
      div_q  <= div_n;
      bypass <= (e_n == '0);
    end
  end

  assign fout = bypass ? vco_clk : div_q;
endmodule

// File: rtl/post_div_pdstep_chk.sv
module post_div_pdstep_chk #(
  parameter int SW       = 3,
  parameter int EW       = 3,
  parameter int MAXE     = 7,
  parameter int PD_STEPS = 4
) (
  input logic            vco_clk,
  input logic            ref_clk,
  input logic            rst_n,
  input logic            pd_s,
  input logic [SW-1:0]   step,
  input logic [SW-1:0]   step_gray,
  input logic [EW-1:0]   e_act,
  input logic [MAXE-1:0] cnt
);
  AST_STEP_LIMIT: assert property (@(posedge ref_clk) disable iff (!rst_n)
    step <= PD_STEPS); // R3
  AST_STEP_UNIT: assert property (@(posedge ref_clk) disable iff (!rst_n)
    (step == $past(step)) || (step == $past(step) + 1) || (step + 1 == $past(step))); // R4
  AST_GRAY_ADJ: assert property (@(posedge ref_clk) disable iff (!rst_n)
    $countones(step_gray ^ $past(step_gray)) <= 1); // R4
  AST_PD_HOLD: assert property (@(posedge ref_clk) disable iff (!rst_n)
    (pd_s && step == PD_STEPS) |=> (step == PD_STEPS)); // R3
  AST_IDLE_HOLD: assert property (@(posedge ref_clk) disable iff (!rst_n)
    (!pd_s && step == 0) |=> (step == 0)); // R5
  AST_EDGE_ONLY: assert property (@(posedge vco_clk) disable iff (!rst_n)
    (cnt != 0) |-> $stable(e_act)); // R6
  AST_CNT_BOUND: assert property (@(posedge vco_clk) disable iff (!rst_n)
    cnt <= ~({MAXE{1'b1}} << e_act)); // R2
endmodule

bind post_div_pdstep post_div_pdstep_chk #(
  .SW(SW), .EW(EW), .MAXE(MAXE), .PD_STEPS(PD_STEPS)
) chk_i (
  .vco_clk(vco_clk), .ref_clk(ref_clk), .rst_n(rst_n), .pd_s(pd_s),
  .step(step), .step_gray(step_gray), .e_act(e_act), .cnt(cnt)
);

// File: tb/post_div_pdstep_tb_top.sv
`timescale 1ns/1ps
module post_div_pdstep_tb_top;
  logic vco_clk = 0, ref_clk = 0, rst_n = 0, pwr_dn = 0;
  logic [1:0] nsel = 0;
  logic fout;

  always #2.5 vco_clk = ~vco_clk;
  always #20  ref_clk = ~ref_clk;

  post_div_pdstep dut_i (.vco_clk(vco_clk), .ref_clk(ref_clk), .rst_n(rst_n),
                         .nsel(nsel), .pwr_dn(pwr_dn), .fout(fout));

  typedef struct { int cyc; string req; } exp_t;
  exp_t exp_q[$];
  int total = 0, bad = 0;
  bit mon_on = 0, have_prev = 0, dwell_on = 0, have_chg = 0, done = 0;
  int last_cyc = 0;
  realtime t_rise, t_fall, t_chg;

  task automatic chk(bit ok, string req, string what, int act, int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  task automatic push(int cyc, string req);
    exp_t e; e.cyc = cyc; e.req = req; exp_q.push_back(e);
  endtask

  task automatic drained(string req);
    chk(exp_q.size() == 0, req, "expected periods left unseen", exp_q.size(), 0);
    exp_q.delete();
  endtask

  task automatic wait_ref(int n);
    repeat (n) @(negedge ref_clk);
  endtask

  always @(negedge fout) if (mon_on) t_fall = $realtime;

  always @(posedge fout) if (mon_on) begin
    realtime now, dt, ht;
    int cyc;
    now = $realtime;
    if (have_prev) begin
      dt  = now - t_rise;
      ht  = t_fall - t_rise;
      cyc = $rtoi(dt / 5.0 + 0.5);
      chk(cyc >= 1 && cyc <= 128 && (cyc & (cyc - 1)) == 0 &&
          (dt - cyc * 5.0 < 0.05) && (cyc * 5.0 - dt < 0.05),
          "R6", "period not a whole power of two (ps)", $rtoi(dt * 1000), cyc * 5000);
      chk((2 * ht - dt < 0.05) && (dt - 2 * ht < 0.05), "R2", "high time (ps)",
          $rtoi(ht * 1000), $rtoi(dt * 500));
      if (cyc != last_cyc) begin
        if (exp_q.size() == 0) begin
          chk(0, "R6", "unexpected period change", cyc, last_cyc);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          chk(cyc == e.cyc, e.req, "period in vco cycles", cyc, e.cyc);
        end
        if (dwell_on && have_chg)
          chk((now - t_chg) > 440.0 && (now - t_chg) < 840.0, "R4", "step dwell (ns)",
              $rtoi(now - t_chg), 640);
        t_chg = now; have_chg = 1;
        last_cyc = cyc;
      end
    end
    have_prev = 1;
    t_rise = now;
  end

  task automatic do_reset();
    mon_on = 0; have_prev = 0; last_cyc = 0; have_chg = 0;
    rst_n = 0;
    repeat (3) begin
      @(negedge vco_clk);
      chk(fout == 1'b0, "R7", "fout during reset", fout, 0);
    end
    #1.2 chk(fout == 1'b0, "R7", "fout during reset, high vco phase", fout, 0);
    @(negedge ref_clk) rst_n = 1;
    mon_on = 1;
  endtask

  initial begin
    // reset and static ratios
    push(1, "R7");
    do_reset();
    wait_ref(10);
    drained("R7");
    for (int n = 1; n < 4; n++) begin
      push(1 << n, "R1");
      nsel = 2'(n);
      wait_ref(10);
      drained("R1");
    end
    push(1, "R1"); nsel = 0; wait_ref(10); drained("R1");

    // full entry and exit at divide-by-1, with dwell checks
    dwell_on = 1; have_chg = 0;
    push(2, "R3"); push(4, "R3"); push(8, "R3"); push(16, "R3");
    pwr_dn = 1; wait_ref(100); drained("R3");
    have_chg = 0;
    push(8, "R5"); push(4, "R5"); push(2, "R5"); push(1, "R5");
    pwr_dn = 0; wait_ref(100); drained("R5");
    dwell_on = 0;

    // entry and exit on top of divide-by-4
    push(4, "R1"); nsel = 2; wait_ref(10); drained("R1");
    push(8, "R3"); push(16, "R3"); push(32, "R3"); push(64, "R3");
    pwr_dn = 1; wait_ref(100); drained("R3");
    push(32, "R5"); push(16, "R5"); push(8, "R5"); push(4, "R5");
    pwr_dn = 0; wait_ref(100); drained("R5");

    // early release reverses from the step reached
    push(1, "R8"); nsel = 0; wait_ref(10); drained("R8");
    push(2, "R8"); push(4, "R8"); push(2, "R8"); push(1, "R8");
    pwr_dn = 1; wait_ref(40); pwr_dn = 0; wait_ref(100); drained("R8");

    // reset in the middle of a power-down sequence
    push(2, "R1"); nsel = 1; wait_ref(10); drained("R1");
    push(4, "R3"); push(8, "R3");
    pwr_dn = 1; wait_ref(45); drained("R3");
    pwr_dn = 0;
    push(2, "R7");
    do_reset();
    wait_ref(60);
    drained("R7");

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #400us;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule